// File: doc/BRIEF.md
# Character Display Host Register Interface

This block is the processor-facing side of a character display controller. A host drives a parallel bus made of a register-select line, a read/write line, an enable strobe and an 8-bit data bus. The two select lines are decoded into four access kinds: instruction write, status read, data write and data read. Instructions move the address counter, choose which of the two on-chip memories later data accesses reach, and set the step direction. Data accesses move bytes between the host and either the 128-byte display memory or the smaller glyph-pattern memory. The address counter steps by one after every data access.

All bus lines are brought into the clock domain through a synchronizer. An access takes effect on the falling edge of the enable strobe. On a read, the block drives the data bus from the rising edge of the strobe until its falling edge. At all other times the output-enable is low, which stands for a released bus. Each accepted instruction keeps a busy flag high for a fixed number of clock cycles, and while that flag is high any further instruction is dropped. A status read returns the flag together with the live address counter. Data reads are served from a staging register that holds the byte at the current address. This register reloads whenever the address or the memory contents change.

The bus is a strobed register port, not a stream. No valid/ready handshake exists and no back-pressure is applied. The host paces itself by polling the busy flag.

Top module: `hif_char_host`

## Requirements
- R1: After reset the busy flag is 0, the address counter is 0x00, the display memory is the data target, the step direction is increment and the bus output-enable is 0.
- R2: A status read (select=0, read=1) returns the busy flag on bit 7 and the 7-bit address counter on bits 6..0.
- R3: The instruction 1aaaaaaa loads aaaaaaa into the address counter and makes the display memory (128 bytes) the data target.
- R4: The instruction 01aaaaaa loads aaaaaa into the address counter and makes the glyph memory (64 bytes) the data target.
- R5: An accepted instruction sets the busy flag for BUSY_CYCLES clock cycles. After that the flag returns to 0.
- R6: An instruction written while the busy flag is 1 has no effect on the address counter, the data target or the step direction.
- R7: A data write (select=1, read=0) stores the byte at the address counter in the selected memory, then steps the counter by one.
- R8: A data read (select=1, read=1) returns the byte stored at the address counter in the selected memory, then steps the counter by one.
- R9: The instruction 000001d0 sets the step direction: d=1 increments and d=0 decrements. This instruction leaves the counter unchanged.
- R10: The counter wraps modulo the size of the selected memory: 0x7F+1 gives 0x00 and 0x00-1 gives 0x7F in the display memory, and 0x3F+1 gives 0x00 in the glyph memory.
- R11: The output-enable is 1 only while the strobe is high during a read access. It stays 0 for writes and whenever the strobe is low.
- R12: The two memories are separate. A write to glyph address N leaves display address N unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | 0 selects instruction/status, 1 selects data |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_strobe | input | 1 | Enable strobe; the access takes effect on its falling edge |
| bus_din | input | 8 | Data from the host |
| bus_dout | output | 8 | Data to the host (0 when not driving) |
| bus_oe | output | 1 | High while the block drives the data bus |

## Verification
The bench attacks the wrap points of the address counter: decrementing past 0x00, incrementing past 0x7F, and glyph addressing past 0x3F. A design that wraps on the wrong width would report 0x40 or read the wrong byte. It sends a second instruction while the first is still busy and then checks the address. A design that does not refuse the instruction would show the second address. It reads back through the staging register right after a change of address. A design that does not refresh that register would return a stale byte. It writes the same index in both memories. A design that shares storage between them would return the glyph byte from the display memory. Output-enable is checked during write strobes, where a design that drives the bus on writes would fail.

// File: rtl/hif_pkg.sv
package hif_pkg;
  // Access kind, coded as {select, read}
  typedef enum logic [1:0] {
    ACC_INSTR_WR = 2'b00,
    ACC_STATUS   = 2'b01,
    ACC_DATA_WR  = 2'b10,
    ACC_DATA_RD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic       strobe;
    logic       sel;
    logic       rd;
    logic [7:0] d;
  } bus_word_t;
endpackage

// File: rtl/hif_bus_sync.sv
module hif_bus_sync
  import hif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_rd,
  input  logic       bus_strobe,
  input  logic [7:0] bus_din,
  output logic       commit,
  output logic       rd_start,
  output logic       rd_phase,
  output acc_e       acc,
  output logic [7:0] wdata
);
  bus_word_t stage [SYNC_STAGES];
  logic      strobe_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else if (g == 0) stage[g] <= '{bus_strobe, bus_sel, bus_rd, bus_din};
        else stage[g] <= stage[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  logic s_strobe, rise, fall;
  assign s_strobe = stage[SYNC_STAGES-1].strobe;
  assign rise     = s_strobe & ~strobe_q;
  assign fall     = ~s_strobe & strobe_q;
  assign acc      = acc_e'({stage[SYNC_STAGES-1].sel, stage[SYNC_STAGES-1].rd});
  assign wdata    = stage[SYNC_STAGES-1].d;
  assign commit   = fall;
  assign rd_start = rise & stage[SYNC_STAGES-1].rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      rd_phase <= 1'b0;
    end else begin
      strobe_q <= s_strobe;
      if (rd_start) rd_phase <= 1'b1;
      else if (fall) rd_phase <= 1'b0;
    end
  end

  // R11: the bus is driven only inside a strobe
  assert_drive_in_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> strobe_q);
endmodule

// File: rtl/hif_ram.sv
module hif_ram #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/hif_ctrl.sv
module hif_ctrl
  import hif_pkg::*;
#(
  parameter int AC_W        = 7,
  parameter int CG_AW       = 6,
  parameter int BUSY_CYCLES = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  acc_e            acc,
  input  logic [7:0]      wdata,
  output logic [AC_W-1:0] ac,
  output logic            busy,
  output logic            sel_cg,
  output logic            incr,
  output logic            dd_we,
  output logic            cg_we,
  output logic            data_acc
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [BW-1:0]   busy_cnt;
  logic            instr_ok;
  logic [AC_W-1:0] ac_step, ac_mask;

  assign instr_ok = commit && (acc == ACC_INSTR_WR) && !busy;
  assign data_acc = commit && (acc == ACC_DATA_WR || acc == ACC_DATA_RD);
  assign dd_we    = commit && (acc == ACC_DATA_WR) && !sel_cg;
  assign cg_we    = commit && (acc == ACC_DATA_WR) && sel_cg;
  assign busy     = (busy_cnt != '0);
  assign ac_mask  = sel_cg ? AC_W'((1 << CG_AW) - 1) : '1;
  assign ac_step  = (incr ? ac + AC_W'(1) : ac - AC_W'(1)) & ac_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      ac       <= '0;
      sel_cg   <= 1'b0;
      incr     <= 1'b1;
    end else begin
      if (instr_ok) busy_cnt <= BW'(BUSY_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - BW'(1);

      if (instr_ok) begin
        if (wdata[7]) begin
          ac     <= wdata[AC_W-1:0];
          sel_cg <= 1'b0;
        end else if (wdata[6]) begin
          ac     <= AC_W'(wdata[CG_AW-1:0]);
          sel_cg <= 1'b1;
        end else if (wdata[5:2] == 4'b0001) begin
          incr <= wdata[1];
        end
      end else if (data_acc) begin
        ac <= ac_step;
      end
    end
  end

  // R5: an accepted instruction raises busy
  assert_busy_after_instr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ok |=> busy);
  // R6: refused instruction leaves state untouched
  assert_refuse_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && acc == ACC_INSTR_WR && busy) |=> ($stable(ac) && $stable(sel_cg) && $stable(incr)));
  // R7: display-memory access in increment mode moves the counter up by one
  assert_step_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && incr && !sel_cg) |=> (ac == AC_W'($past(ac) + AC_W'(1))));
  // R10: the glyph counter stays inside the glyph memory
  assert_cg_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cg |-> ((ac >> CG_AW) == '0));
endmodule

// File: rtl/hif_char_host.sv
module hif_char_host
  import hif_pkg::*;
#(
  parameter int DD_DEPTH    = 128,
  parameter int CG_DEPTH    = 64,
  parameter int BUSY_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_rd,
  input  logic       bus_strobe,
  input  logic [7:0] bus_din,
  output logic [7:0] bus_dout,
  output logic       bus_oe
);
  localparam int AC_W  = $clog2(DD_DEPTH);
  localparam int CG_AW = $clog2(CG_DEPTH);

  logic            commit, rd_start, rd_phase, busy, sel_cg, incr;
  logic            dd_we, cg_we, data_acc;
  acc_e            acc;
  logic [7:0]      wdata, dd_rdata, cg_rdata, stage_q, out_q;
  logic [AC_W-1:0] ac;

  hif_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_strobe(bus_strobe), .bus_din(bus_din), .commit(commit),
    .rd_start(rd_start), .rd_phase(rd_phase), .acc(acc), .wdata(wdata)
  );

  hif_ctrl #(.AC_W(AC_W), .CG_AW(CG_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .commit(commit), .acc(acc), .wdata(wdata),
    .ac(ac), .busy(busy), .sel_cg(sel_cg), .incr(incr),
    .dd_we(dd_we), .cg_we(cg_we), .data_acc(data_acc)
  );

  hif_ram #(.DEPTH(DD_DEPTH)) u_ddram (
    .clk(clk), .we(dd_we), .addr(ac), .wdata(wdata), .rdata(dd_rdata)
  );

  hif_ram #(.DEPTH(CG_DEPTH)) u_cgram (
    .clk(clk), .we(cg_we), .addr(ac[CG_AW-1:0]), .wdata(wdata), .rdata(cg_rdata)
  );

  // Staging register: follows the current address except while a read is served
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (!rd_phase && !rd_start) stage_q <= sel_cg ? cg_rdata : dd_rdata;
      if (rd_start) out_q <= (acc == ACC_STATUS) ? {busy, ac} : stage_q;
    end
  end

  assign bus_oe   = rd_phase;
  assign bus_dout = rd_phase ? out_q : 8'h00;

  // R11: output-enable never rises on a write access
  assert_no_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !acc[0]) |-> !$past(bus_oe));
  // R8: a data read steps the counter after completion
  assert_read_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && acc == ACC_DATA_RD) |=> !$stable(ac));
endmodule

// File: tb/hif_char_host_tb.sv
module hif_char_host_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_strobe = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;

  int checks = 0, failures = 0;
  byte unsigned exp_q[$];
  string        tag_q[$];
  event         sample_ev;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  hif_char_host u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_strobe(bus_strobe), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read bytes as the design presents them
  initial begin
    forever begin
      @(sample_ev);
      check({tag_q[0], " oe"}, {7'b0, bus_oe}, 8'h01);
      check(tag_q[0], bus_dout, exp_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic access(input logic sel, input logic rd, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_rd = rd; bus_din = d;
    repeat (2) @(negedge clk);
    bus_strobe = 1'b1;
    repeat (6) @(negedge clk);
    if (rd) -> sample_ev;
    else check("R11 write strobe oe", {7'b0, bus_oe}, 8'h00);
    #1;
    bus_strobe = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd_expect(input logic sel, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    access(sel, 1'b1, 8'h00);
  endtask

  task automatic instr(input logic [7:0] code);
    access(1'b0, 1'b0, code);
    repeat (50) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 oe after reset", {7'b0, bus_oe}, 8'h00);
    rd_expect(1'b0, 8'h00, "R1 R2 status after reset");

    instr(8'h85);                                   // R3 display address 0x05
    rd_expect(1'b0, 8'h05, "R3 address loaded");
    access(1'b1, 1'b0, 8'h41);
    access(1'b1, 1'b0, 8'h42);
    access(1'b1, 1'b0, 8'h43);
    rd_expect(1'b0, 8'h08, "R7 counter after writes");
    instr(8'h85);
    rd_expect(1'b1, 8'h41, "R8 read 0x05");
    rd_expect(1'b1, 8'h42, "R8 read 0x06");
    rd_expect(1'b1, 8'h43, "R8 read 0x07");
    rd_expect(1'b0, 8'h08, "R8 counter after reads");
    check("R11 oe idle", {7'b0, bus_oe}, 8'h00);

    // R5/R6: busy window and refused instruction
    access(1'b0, 1'b0, 8'h90);
    rd_expect(1'b0, 8'h90, "R5 busy set with address 0x10");
    access(1'b0, 1'b0, 8'hA0);                      // dropped while busy
    repeat (60) @(negedge clk);
    rd_expect(1'b0, 8'h10, "R5 R6 busy cleared and second instruction refused");

    // R9/R10: decrement across zero
    instr(8'h81);
    instr(8'h04);
    rd_expect(1'b0, 8'h01, "R9 entry mode keeps counter");
    access(1'b1, 1'b0, 8'hAA);
    access(1'b1, 1'b0, 8'hBB);
    rd_expect(1'b0, 8'h7F, "R10 decrement wraps to 0x7F");
    instr(8'h06);
    access(1'b1, 1'b0, 8'hCC);
    rd_expect(1'b0, 8'h00, "R10 increment wraps to 0x00");
    rd_expect(1'b1, 8'hBB, "R8 R9 byte at 0x00");
    instr(8'hFF);
    rd_expect(1'b1, 8'hCC, "R7 byte at 0x7F");

    // R4/R10/R12: glyph memory
    instr(8'h7F);
    rd_expect(1'b0, 8'h3F, "R4 glyph address 0x3F");
    access(1'b1, 1'b0, 8'h11);
    rd_expect(1'b0, 8'h00, "R10 glyph wraps to 0x00");
    access(1'b1, 1'b0, 8'h22);
    instr(8'h7F);
    rd_expect(1'b1, 8'h11, "R4 glyph read 0x3F");
    rd_expect(1'b1, 8'h22, "R4 glyph read 0x00");
    instr(8'h80);
    rd_expect(1'b1, 8'hBB, "R12 display 0x00 untouched by glyph write");
    rd_expect(1'b1, 8'hAA, "R12 display 0x01 intact");

    repeat (5) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule